// File: doc/BRIEF.md
# Dual-Channel ADC Serial Port Sequencer

This block is the digital serial side of a two-channel, simultaneous-sampling converter. Each conversion start latches two sample words, one per channel. The block then counts rising edges of the serial clock and presents the bits MSB first. In dual-output mode each channel has its own data pin. In single-output mode channel 2 follows channel 1 on the first pin, and the second pin is released.

The block also watches the edge count at which the conversion-start input rises, and uses that count to choose the next behaviour. A rise late in the frame starts a conversion and leaves the pins tri-stated between frames. A rise in the middle of the frame starts a conversion and holds the pins low between frames. A rise early in the frame steps the part down, first to partial power-down and then to full power-down. A separate chip-select input forces full power-down while it is high. The block reports its power state and a reference-ready flag. After the reference is switched on, the flag waits a programmable number of system clocks before it asserts.

All inputs are synchronous to the system clock. A rising edge on the serial clock or on the conversion-start input takes effect at the first system clock edge that sees the input high after it was low.

Top module: `dual_adc_serial_seq`

## Requirements
- R1: After reset the power state is active (2'b00), ref_ready is 1, both data pins are released (output enable 0), and the edge count is at its saturated end value.
- R2: With single_out low, after the Nth serial-clock edge of a frame (N = 4..15), dout1 carries bit 15-N of channel 1 and dout2 carries bit 15-N of channel 2. Both enables are 1 during these edges.
- R3: With single_out high, dout1 carries channel 1 for N = 4..15 and bit 27-N of channel 2 for N = 16..27. dout2_oe stays 0 throughout.
- R4: A conversion start at an edge count of 28 or of 0..2 selects single-conversion behaviour. Outside the data slots the enabled pins are released (enable 0).
- R5: A conversion start at an edge count of 14..27 selects continuous behaviour. Outside the data slots the pins that are in use are driven low (enable 1, data 0).
- R6: In the active state, a conversion-start rise at an edge count of 3..13 enters partial power-down (2'b01). It restarts the edge count and releases both pins. ref_ready is unchanged.
- R7: In partial power-down, a second rise at an edge count of 3..13 enters full power-down (2'b10) and clears ref_ready.
- R8: Any other conversion-start rise in a power-down state returns the block to active and starts a conversion. From partial power-down, ref_ready stays 1. From full power-down, ref_ready rises WAKE_CYCLES system clocks after the edge that saw the rise.
- R9: While cs is high the state is full power-down, ref_ready is 0, both pins are released, and conversion-start rises are ignored. When cs falls the block returns to active, and ref_ready rises WAKE_CYCLES clocks after the edge that saw the fall.
- R10: The edge count saturates at 28, so further serial-clock edges leave the outputs at their idle level. Sample inputs that change after a conversion start do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnvst | input | 1 | Conversion start / power-step request |
| sclk | input | 1 | Serial clock, sampled synchronously |
| cs | input | 1 | High forces full power-down |
| single_out | input | 1 | 1 = both channels on dout1, 0 = one pin per channel |
| ch1_data | input | DATA_W | Channel 1 sample word |
| ch2_data | input | DATA_W | Channel 2 sample word |
| dout1 | output | 1 | Serial data pin 1 |
| dout1_oe | output | 1 | Output enable of pin 1 (0 = high impedance) |
| dout2 | output | 1 | Serial data pin 2 |
| dout2_oe | output | 1 | Output enable of pin 2 (0 = high impedance) |
| pwr_state | output | 2 | 00 active, 01 partial power-down, 10 full power-down |
| ref_ready | output | 1 | Reference enabled and settled |

## Verification
The bench probes the edges of each decode window: starts at edge counts 0, 1, 3, 13, 20 and 28. A design with an off-by-one window would misclassify a start as a power step or a conversion, and the pins or the power state would then differ. It times the wake-up exactly, on both sides of the expected cycle, after a full power-down and after a chip-select release. A counter that is one short, or that never reloads, would show the flag rise a clock early or not at all. It runs extra serial-clock edges past the end of the frame and changes the sample inputs mid-frame. A wrapping counter would replay data, and an unlatched sample would leak the new word onto the pins.

// File: rtl/dual_adc_serial_seq.sv
`timescale 1ns/1ps
module dual_adc_serial_seq #(
  parameter int DATA_W      = 12,
  parameter int WAKE_CYCLES = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnvst,
  input  logic              sclk,
  input  logic              cs,
  input  logic              single_out,
  input  logic [DATA_W-1:0] ch1_data,
  input  logic [DATA_W-1:0] ch2_data,
  output logic              dout1,
  output logic              dout1_oe,
  output logic              dout2,
  output logic              dout2_oe,
  output logic [1:0]        pwr_state,
  output logic              ref_ready
);
  localparam int FIRST  = 4;
  localparam int CH2_AT = FIRST + DATA_W;
  localparam int LAST   = FIRST + 2 * DATA_W;
  localparam int CW     = $clog2(LAST + 1);
  localparam int WW     = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] C_FIRST = CW'(FIRST);
  localparam logic [CW-1:0] C_PDMIN = CW'(FIRST - 1);
  localparam logic [CW-1:0] C_CONT  = CW'(LAST / 2);
  localparam logic [CW-1:0] C_CH2   = CW'(CH2_AT);
  localparam logic [CW-1:0] C_LAST  = CW'(LAST);
  localparam logic [WW-1:0] C_WAKE  = WW'(WAKE_CYCLES);

  typedef enum logic [1:0] {PS_ACT = 2'b00, PS_PART = 2'b01, PS_FULL = 2'b10} pwr_t;

  pwr_t              ps;
  logic              sclk_q, cnvst_q, cs_q, cont, ref_on;
  logic [CW-1:0]     cnt;
  logic [WW-1:0]     wake;
  logic [DATA_W-1:0] d1, d2;

  wire cv_rise   = cnvst & ~cnvst_q;
  wire sc_rise   = sclk & ~sclk_q;
  wire cs_fall   = cs_q & ~cs;
  wire pd_win    = (cnt >= C_PDMIN) && (cnt < C_CONT);
  wire cont_win  = (cnt >= C_CONT) && (cnt < C_LAST);
  wire act       = (ps == PS_ACT);
  wire in1       = (cnt >= C_FIRST) && (cnt < C_CH2);
  wire in2s      = single_out && (cnt >= C_CH2) && (cnt < C_LAST);

  wire [CW-1:0]     idx1 = C_CH2 - CW'(1) - cnt;
  wire [CW-1:0]     idx2 = C_LAST - CW'(1) - cnt;
  wire [DATA_W-1:0] s1a  = d1 >> idx1;
  wire [DATA_W-1:0] s2a  = d2 >> idx1;
  wire [DATA_W-1:0] s2b  = d2 >> idx2;

  assign dout1_oe  = act && (in1 || in2s || cont);
  assign dout1     = in1 ? s1a[0] : (in2s ? s2b[0] : 1'b0);
  assign dout2_oe  = act && !single_out && (in1 || cont);
  assign dout2     = (in1 && !single_out) ? s2a[0] : 1'b0;
  assign pwr_state = ps;
  assign ref_ready = ref_on && (wake == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; cnvst_q <= 1'b0; cs_q <= 1'b0;
      cnt <= C_LAST; cont <= 1'b0; ps <= PS_ACT;
      ref_on <= 1'b1; wake <= '0; d1 <= '0; d2 <= '0;
    end else begin
      sclk_q  <= sclk;
      cnvst_q <= cnvst;
      cs_q    <= cs;
      if (wake != '0) wake <= wake - WW'(1);
      if (cs) begin
        ps <= PS_FULL; ref_on <= 1'b0; wake <= '0; cnt <= C_LAST; cont <= 1'b0;
      end else if (cs_fall) begin
        ps <= PS_ACT; ref_on <= 1'b1; wake <= C_WAKE;
      end else if (cv_rise) begin
        cnt <= '0;
        if (pd_win && ps == PS_ACT) begin
          ps <= PS_PART;
        end else if (pd_win && ps == PS_PART) begin
          ps <= PS_FULL; ref_on <= 1'b0; wake <= '0;
        end else begin
          d1 <= ch1_data; d2 <= ch2_data; cont <= cont_win; ps <= PS_ACT;
          if (ps == PS_FULL) begin
            ref_on <= 1'b1; wake <= C_WAKE;
          end
        end
      end else if (sc_rise && cnt != C_LAST) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assert_cnt_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == C_LAST && !cv_rise) |=> cnt == C_LAST);
  assert_single_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && cv_rise && !cs && cnt == C_LAST) |=> !dout1_oe && !dout2_oe);
  assert_cont_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act && cv_rise && !cs && cont_win) |=> dout1_oe && !dout1);
  assert_ppd_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act && cv_rise && !cs && pd_win) |=> pwr_state == 2'b01 && !dout1_oe && !dout2_oe);
  assert_fpd_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ps == PS_PART && cv_rise && !cs && pd_win) |=> pwr_state == 2'b10 && !ref_ready);
  assert_ready_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_ready) |-> !cs);
  assert_cs_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs |=> pwr_state == 2'b10 && !ref_ready && !dout1_oe && !dout2_oe);
  assert_dual_pin2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (single_out && $stable(single_out)) |-> !dout2_oe);
endmodule

// File: tb/dual_adc_serial_seq_test.sv
`timescale 1ns/1ps
module dual_adc_serial_seq_test;
  localparam int W = 20;
  logic clk = 1'b0, rst_n = 1'b0, cnvst = 1'b0, sclk = 1'b0, cs = 1'b0, single_out = 1'b0;
  logic [11:0] ch1_data = '0, ch2_data = '0;
  logic dout1, dout1_oe, dout2, dout2_oe, ref_ready;
  logic [1:0] pwr_state;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dual_adc_serial_seq #(.DATA_W(12), .WAKE_CYCLES(W)) uut (
    .clk(clk), .rst_n(rst_n), .cnvst(cnvst), .sclk(sclk), .cs(cs),
    .single_out(single_out), .ch1_data(ch1_data), .ch2_data(ch2_data),
    .dout1(dout1), .dout1_oe(dout1_oe), .dout2(dout2), .dout2_oe(dout2_oe),
    .pwr_state(pwr_state), .ref_ready(ref_ready));

  localparam logic [24:0] VEC [0:3] = '{
    {1'b0, 12'hA5C, 12'h3F1},
    {1'b1, 12'h801, 12'h7FE},
    {1'b1, 12'hFFF, 12'h000},
    {1'b0, 12'h000, 12'hFFF}};

  task automatic chk(input string msg, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sclk_pulse();
    @(negedge clk) sclk = 1'b1;
    @(negedge clk) sclk = 1'b0;
  endtask

  task automatic cnvst_pulse();
    @(negedge clk) cnvst = 1'b1;
    @(negedge clk) cnvst = 1'b0;
    @(negedge clk);
  endtask

  task automatic sclks(input int n);
    for (int i = 0; i < n; i++) sclk_pulse();
  endtask

  task automatic frame(input bit sg, input logic [11:0] c1, input logic [11:0] c2,
                       input bit cont, input string tag);
    for (int e = 0; e <= 33; e++) begin
      int k;
      logic [1:0] x1, x2;
      if (e > 0) sclk_pulse();
      k = (e > 28) ? 28 : e;
      if (k >= 4 && k <= 15) x1 = {1'b1, c1[15-k]};
      else if (sg && k >= 16 && k <= 27) x1 = {1'b1, c2[27-k]};
      else x1 = {cont, 1'b0};
      if (sg) x2 = 2'b00;
      else if (k >= 4 && k <= 15) x2 = {1'b1, c2[15-k]};
      else x2 = {cont, 1'b0};
      chk($sformatf("%s dout1 edge %0d", (e > 28) ? "R10" : tag, e), {dout1_oe, dout1}, x1);
      chk($sformatf("%s dout2 edge %0d", (e > 28) ? "R10" : tag, e), {dout2_oe, dout2}, x2);
    end
  endtask

  initial begin
    #3ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 pwr_state", pwr_state, 0);
    chk("R1 ref_ready", ref_ready, 1);
    chk("R1 oe", {dout1_oe, dout2_oe}, 0);

    for (int v = 0; v < 4; v++) begin
      single_out = VEC[v][24]; ch1_data = VEC[v][23:12]; ch2_data = VEC[v][11:0];
      cnvst_pulse();
      frame(VEC[v][24], VEC[v][23:12], VEC[v][11:0], 1'b0, VEC[v][24] ? "R3" : "R2");
    end

    // R5 continuous start at edge 20, inputs changed mid-frame (R10)
    single_out = 1'b0; cnvst_pulse(); sclks(20);
    ch1_data = 12'h5A3; ch2_data = 12'hC3C;
    cnvst_pulse();
    ch1_data = 12'h000; ch2_data = 12'hFFF;
    frame(1'b0, 12'h5A3, 12'hC3C, 1'b1, "R5");
    // R4 start at 28 returns to released idle
    single_out = 1'b1; ch1_data = 12'h3C5; ch2_data = 12'h9A6;
    cnvst_pulse();
    frame(1'b1, 12'h3C5, 12'h9A6, 1'b0, "R4");
    // R4 start at edge 1 is a conversion, not a power step
    cnvst_pulse(); sclks(1);
    ch1_data = 12'h123; ch2_data = 12'h456;
    cnvst_pulse();
    chk("R4 start@1 pwr", pwr_state, 0);
    frame(1'b1, 12'h123, 12'h456, 1'b0, "R4");

    // R6 partial at edge 5, R7 full at edge 3, R8 wake from full
    cnvst_pulse(); sclks(5); cnvst_pulse();
    chk("R6 pwr", pwr_state, 1);
    chk("R6 ref_ready", ref_ready, 1);
    chk("R6 oe", {dout1_oe, dout2_oe}, 0);
    sclks(3); cnvst_pulse();
    chk("R7 pwr", pwr_state, 2);
    chk("R7 ref_ready", ref_ready, 0);
    single_out = 1'b0; ch1_data = 12'hE71; ch2_data = 12'h18E;
    cnvst_pulse();
    chk("R8 pwr", pwr_state, 0);
    repeat (W - 2) tick();
    chk("R8 ready early", ref_ready, 0);
    tick();
    chk("R8 ready on time", ref_ready, 1);
    frame(1'b0, 12'hE71, 12'h18E, 1'b0, "R8");

    // R6 boundary edge 13, then R8 wake from partial keeps reference
    cnvst_pulse(); sclks(13); cnvst_pulse();
    chk("R6 edge13 pwr", pwr_state, 1);
    ch1_data = 12'hB0D; ch2_data = 12'h4F2;
    cnvst_pulse();
    chk("R8 partial wake pwr", pwr_state, 0);
    chk("R8 partial wake ready", ref_ready, 1);
    frame(1'b0, 12'hB0D, 12'h4F2, 1'b0, "R8");

    // R9 chip select
    tick(); cs = 1'b1; tick();
    chk("R9 pwr", pwr_state, 2);
    chk("R9 ref_ready", ref_ready, 0);
    cnvst_pulse();
    chk("R9 cnvst ignored", pwr_state, 2);
    chk("R9 oe", {dout1_oe, dout2_oe}, 0);
    cs = 1'b0;
    repeat (W) tick();
    chk("R9 ready early", ref_ready, 0);
    chk("R9 pwr after release", pwr_state, 0);
    tick();
    chk("R9 ready on time", ref_ready, 1);
    chk("R9 idle oe", {dout1_oe, dout2_oe}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule